// File: doc/BRIEF.md
# Outbound PCI Window Decoder

This block is the address decoder of a host-to-PCI bridge. It looks at CPU-side memory addresses and decides whether each one is passed on to PCI memory space. The top 256 MiB of the 32-bit address space, from 0xF0000000 upward, is cut into 32 chunks of 8 MiB each. A chunk is forwarded only when software has set its bit in an enable mask and a two-bit forwarding-mode field in a control register holds the "forward" code. The lowest chunk holds firmware and the highest chunk holds the bridge's own registers, so neither chunk is ever forwarded, whatever the mask says. A forwarded address reaches PCI memory space unchanged.

The same block also steers addresses issued by PCI bus masters. Each such address is sent to system memory, to PCI memory or to CPU space, or it is marked as having no target. Software programs the two registers through a single-cycle write port. Each decode result is registered and appears one clock after its request is sampled.

Top module: `pciwin_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cpuHit is 0, cpuPciAddr is 0, bmTgtValid is 0 and bmTgt is 0.
- R2: A request sampled at a rising edge produces its result after that same edge. When cpuValid is low at that edge, cpuHit is 0 in the following cycle.
- R3: When cpuValid is set, cpuAddr[31:28] is 0xF, chunk index k = cpuAddr[27:23] lies in 1..30 and enable-mask bit k is 1, cpuHit is 1 while the control field is 01.
- R4: Chunk 0 (0xF0000000–0xF07FFFFF) and chunk 31 (0xFF800000–0xFFFFFFFF) never produce cpuHit, even with mask bits 0 and 31 set.
- R5: Control register bits [8:7] must equal binary 01 for any forwarding. The codes 00, 10 and 11 block every chunk, and the other control bits have no effect.
- R6: When cpuHit is 1, cpuPciAddr equals the sampled cpuAddr bit for bit. When cpuHit is 0, cpuPciAddr is 0.
- R7: A valid bus-master address below 0xF0800000 yields bmTgt = 1 (system memory).
- R8: A valid bus-master address from 0xF0800000 to 0xFF7FFFFF (30 chunks) yields bmTgt = 2 (PCI memory).
- R9: A valid bus-master address from 0xFFF00000 to 0xFFFFFFFF yields bmTgt = 3 (CPU space).
- R10: A valid bus-master address from 0xFF800000 to 0xFFEFFFFF yields bmTgt = 0 (no target). bmTgtValid repeats the sampled bmValid. bmTgt is 0 whenever bmTgtValid is 0.
- R11: A write with regSel = 0 loads the enable mask, and a write with regSel = 1 loads the control register. A request in the cycle right after the write's edge is decoded with the new value.
- R12: A CPU address below 0xF0000000 never produces cpuHit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the enable mask, 1 selects the control register |
| regWrData | input | 32 | Register write data |
| cpuValid | input | 1 | CPU request valid |
| cpuAddr | input | 32 | CPU request address |
| bmValid | input | 1 | Bus-master request valid |
| bmAddr | input | 32 | Bus-master request address |
| cpuHit | output | 1 | Registered: CPU address is forwarded to PCI |
| cpuPciAddr | output | 32 | Registered: PCI memory address of the forwarded access |
| bmTgtValid | output | 1 | Registered: bus-master decode result is valid |
| bmTgt | output | 2 | Registered target: 0 none, 1 system, 2 PCI, 3 CPU |

## Verification
The bench uses the default parameters: a 32-bit address, 32 chunks of 8 MiB from 0xF0000000, the mode field at bits [8:7] and forwarding code 01. With these values every chunk can be reached in a single sweep, and both excluded chunks can be hit directly. The exact edges of the bus-master ranges (0xF07FFFFF/0xF0800000, 0xFF7FFFFF/0xFF800000, 0xFFEFFFFF/0xFFF00000) become concrete addresses that the bench probes.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;

  localparam int REG_W = 32;

  // Bus-master target encoding
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SYS  = 2'd1,
    TGT_PCI  = 2'd2,
    TGT_CPU  = 2'd3
  } bmTgt_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             loadMask;
    logic             loadCtl;
    logic [REG_W-1:0] wrData;
    logic             takeCpu;
    logic             takeBm;
  } winStrobe_t;

endpackage

// File: rtl/pciwin_ctrl.sv
module pciwin_ctrl
  import pciwin_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic             cpuValid,
  input  logic             bmValid,
  output winStrobe_t       strb
);

  always_comb begin
    strb.loadMask = regWrEn && !regSel;
    strb.loadCtl  = regWrEn && regSel;
    strb.wrData   = regWrData;
    strb.takeCpu  = cpuValid;
    strb.takeBm   = bmValid;
  end

endmodule

// File: rtl/pciwin_dp.sv
module pciwin_dp
  import pciwin_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                CHUNK_LOG2  = 23,
  parameter int                CHUNK_CNT   = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] CPU_BASE    = 32'hFFF0_0000,
  parameter int                CTL_LSB     = 7,
  parameter int                CTL_W       = 2,
  parameter logic [CTL_W-1:0]  CTL_CODE    = 2'b01
)(
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] bmAddr,
  output logic              cpuHit,
  output logic [ADDR_W-1:0] cpuPciAddr,
  output logic              bmTgtValid,
  output logic [1:0]        bmTgt
);

  localparam int IDX_W  = $clog2(CHUNK_CNT);
  localparam int TAG_LO = CHUNK_LOG2 + IDX_W;
  localparam logic [ADDR_W:0] CHUNK_SIZE = {{ADDR_W{1'b0}}, 1'b1} << CHUNK_LOG2;
  localparam logic [ADDR_W:0] SYS_END = {1'b0, REGION_BASE} + CHUNK_SIZE;
  localparam logic [ADDR_W:0] PCI_END = SYS_END + CHUNK_SIZE * (ADDR_W+1)'(CHUNK_CNT - 2);
  localparam logic [ADDR_W:0] CPU_LO  = {1'b0, CPU_BASE};

  logic [CHUNK_CNT-1:0] maskReg;
  logic [CTL_W-1:0]     ctlField;
  logic [CHUNK_CNT-1:0] chunkEn;

  // Register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg  <= '0;
      ctlField <= '0;
    end else begin
      if (strb.loadMask) maskReg  <= strb.wrData[CHUNK_CNT-1:0];
      if (strb.loadCtl)  ctlField <= strb.wrData[CTL_LSB +: CTL_W];
    end
  end

  // Per-chunk enable, edge chunks tied off
  for (genvar gi = 0; gi < CHUNK_CNT; gi++) begin : g_chunk
    if (gi == 0 || gi == CHUNK_CNT - 1) begin : g_excl
      assign chunkEn[gi] = 1'b0;
    end else begin : g_open
      assign chunkEn[gi] = maskReg[gi];
    end
  end

  // CPU-side decode
  logic [IDX_W-1:0] chunkIdx;
  logic             inRegion;
  logic             fwdOn;
  logic             cpuHitD;

  always_comb begin
    chunkIdx = cpuAddr[CHUNK_LOG2 +: IDX_W];
    inRegion = cpuAddr[ADDR_W-1:TAG_LO] == REGION_BASE[ADDR_W-1:TAG_LO];
    fwdOn    = ctlField == CTL_CODE;
    cpuHitD  = strb.takeCpu && inRegion && fwdOn && chunkEn[chunkIdx];
  end

  // Bus-master steering
  logic [ADDR_W:0] bmWide;
  bmTgt_e          bmTgtD;

  always_comb begin
    bmWide = {1'b0, bmAddr};
    if (!strb.takeBm)         bmTgtD = TGT_NONE;
    else if (bmWide < SYS_END) bmTgtD = TGT_SYS;
    else if (bmWide < PCI_END) bmTgtD = TGT_PCI;
    else if (bmWide >= CPU_LO) bmTgtD = TGT_CPU;
    else                       bmTgtD = TGT_NONE;
  end

  // Output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuHit     <= 1'b0;
      cpuPciAddr <= '0;
      bmTgtValid <= 1'b0;
      bmTgt      <= TGT_NONE;
    end else begin
      cpuHit     <= cpuHitD;
      cpuPciAddr <= cpuHitD ? cpuAddr : '0;
      bmTgtValid <= strb.takeBm;
      bmTgt      <= bmTgtD;
    end
  end

endmodule

// File: rtl/pciwin_decoder.sv
module pciwin_decoder
  import pciwin_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                CHUNK_LOG2  = 23,
  parameter int                CHUNK_CNT   = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] CPU_BASE    = 32'hFFF0_0000,
  parameter int                CTL_LSB     = 7,
  parameter int                CTL_W       = 2,
  parameter logic [CTL_W-1:0]  CTL_CODE    = 2'b01
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              bmValid,
  input  logic [ADDR_W-1:0] bmAddr,
  output logic              cpuHit,
  output logic [ADDR_W-1:0] cpuPciAddr,
  output logic              bmTgtValid,
  output logic [1:0]        bmTgt
);

  winStrobe_t strb;

  pciwin_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regWrData(regWrData),
    .cpuValid (cpuValid),
    .bmValid  (bmValid),
    .strb     (strb)
  );

  pciwin_dp #(
    .ADDR_W     (ADDR_W),
    .CHUNK_LOG2 (CHUNK_LOG2),
    .CHUNK_CNT  (CHUNK_CNT),
    .REGION_BASE(REGION_BASE),
    .CPU_BASE   (CPU_BASE),
    .CTL_LSB    (CTL_LSB),
    .CTL_W      (CTL_W),
    .CTL_CODE   (CTL_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .bmAddr    (bmAddr),
    .cpuHit    (cpuHit),
    .cpuPciAddr(cpuPciAddr),
    .bmTgtValid(bmTgtValid),
    .bmTgt     (bmTgt)
  );

endmodule

// File: rtl/pciwin_chk.sv
module pciwin_chk #(
  parameter int                ADDR_W      = 32,
  parameter int                CHUNK_LOG2  = 23,
  parameter int                CHUNK_CNT   = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] CPU_BASE    = 32'hFFF0_0000
)(
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              bmValid,
  input logic [ADDR_W-1:0] bmAddr,
  input logic              cpuHit,
  input logic [ADDR_W-1:0] cpuPciAddr,
  input logic              bmTgtValid,
  input logic [1:0]        bmTgt
);

  localparam int IDX_W  = $clog2(CHUNK_CNT);
  localparam int TAG_LO = CHUNK_LOG2 + IDX_W;

  // Set once one full cycle out of reset has passed
  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && cpuHit) |-> $past(cpuValid)); // R2

  AST_HIT_ADDR_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && cpuHit) |-> (cpuPciAddr == $past(cpuAddr))); // R6

  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !cpuHit |-> (cpuPciAddr == '0)); // R6

  AST_NO_EDGE_CHUNK: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |-> (cpuPciAddr[CHUNK_LOG2 +: IDX_W] != '0 &&
                cpuPciAddr[CHUNK_LOG2 +: IDX_W] != IDX_W'(CHUNK_CNT - 1))); // R4

  AST_HIT_IN_REGION: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |-> (cpuPciAddr[ADDR_W-1:TAG_LO] == REGION_BASE[ADDR_W-1:TAG_LO])); // R12

  AST_TGT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !bmTgtValid |-> (bmTgt == 2'd0)); // R10

  AST_VALID_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (bmTgtValid == $past(bmValid))); // R10

  AST_CPU_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(bmValid) && $past(bmAddr) >= CPU_BASE) |-> (bmTgt == 2'd3)); // R9

endmodule

bind pciwin_decoder pciwin_chk #(
  .ADDR_W     (ADDR_W),
  .CHUNK_LOG2 (CHUNK_LOG2),
  .CHUNK_CNT  (CHUNK_CNT),
  .REGION_BASE(REGION_BASE),
  .CPU_BASE   (CPU_BASE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuValid  (cpuValid),
  .cpuAddr   (cpuAddr),
  .bmValid   (bmValid),
  .bmAddr    (bmAddr),
  .cpuHit    (cpuHit),
  .cpuPciAddr(cpuPciAddr),
  .bmTgtValid(bmTgtValid),
  .bmTgt     (bmTgt)
);

// File: tb/sim_pciwin_decoder.sv
module sim_pciwin_decoder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic        regSel;
  logic [31:0] regWrData;
  logic        cpuValid;
  logic [31:0] cpuAddr;
  logic        bmValid;
  logic [31:0] bmAddr;
  logic        cpuHit;
  logic [31:0] cpuPciAddr;
  logic        bmTgtValid;
  logic [1:0]  bmTgt;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] maskSh = '0;
  logic [31:0] ctlSh  = '0;

  always #10 clk = ~clk;

  pciwin_decoder u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .cpuValid(cpuValid), .cpuAddr(cpuAddr),
    .bmValid(bmValid), .bmAddr(bmAddr), .cpuHit(cpuHit),
    .cpuPciAddr(cpuPciAddr), .bmTgtValid(bmTgtValid), .bmTgt(bmTgt)
  );

  function automatic logic expHit(logic [31:0] m, logic [31:0] c, logic [31:0] a);
    int k = int'(a[27:23]);
    return (c[8:7] == 2'b01) && (a[31:28] == 4'hF) && k != 0 && k != 31 && m[k];
  endfunction

  function automatic logic [1:0] expTgt(logic [31:0] a);
    if (a < 32'hF080_0000) return 2'd1;
    if (a < 32'hFF80_0000) return 2'd2;
    if (a >= 32'hFFF0_0000) return 2'd3;
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel) ctlSh = d; else maskSh = d;
  endtask

  // Drive at a falling edge, sample one falling edge later
  task automatic cpuProbe(input string req, input logic [31:0] a);
    logic e;
    @(negedge clk);
    cpuValid = 1'b1; cpuAddr = a;
    @(posedge clk);
    @(negedge clk);
    cpuValid = 1'b0;
    e = expHit(maskSh, ctlSh, a);
    check(req, {31'd0, cpuHit}, {31'd0, e});
    check({req, "_R6"}, cpuPciAddr, e ? a : 32'd0);
  endtask

  task automatic bmProbe(input string req, input logic v, input logic [31:0] a);
    @(negedge clk);
    bmValid = v; bmAddr = a;
    @(posedge clk);
    @(negedge clk);
    bmValid = 1'b0;
    check(req, {31'd0, bmTgtValid}, {31'd0, v});
    check(req, {30'd0, bmTgt}, v ? {30'd0, expTgt(a)} : 32'd0);
  endtask

  task automatic testReset;
    check("R1 hit", {31'd0, cpuHit}, 32'd0);
    check("R1 addr", cpuPciAddr, 32'd0);
    check("R1 tvalid", {31'd0, bmTgtValid}, 32'd0);
    check("R1 tgt", {30'd0, bmTgt}, 32'd0);
  endtask

  task automatic testChunkSweep;
    writeReg(1'b1, 32'h0000_0080);
    writeReg(1'b0, 32'hA5A5_A5A5);
    for (int k = 0; k < 32; k++) cpuProbe("R3 sweepA", 32'hF000_0000 + (k << 23) + 32'h124);
    writeReg(1'b0, 32'h5A5A_5A5A);
    for (int k = 0; k < 32; k++) cpuProbe("R3 sweepB", 32'hF000_0000 + (k << 23) + 32'h7F_FFFC);
  endtask

  task automatic testEdgeChunks;
    writeReg(1'b0, 32'hFFFF_FFFF);
    cpuProbe("R4 chunk0", 32'hF000_0004);
    cpuProbe("R4 chunk0 top", 32'hF07F_FFFF);
    cpuProbe("R4 chunk31", 32'hFF80_0000);
    cpuProbe("R4 chunk31 top", 32'hFFFF_FFFF);
    cpuProbe("R3 chunk1 low", 32'hF080_0000);
    cpuProbe("R3 chunk30 top", 32'hFF7F_FFFF);
  endtask

  task automatic testCtlField;
    writeReg(1'b1, 32'hFFFF_FE7F);
    cpuProbe("R5 code00", 32'hF100_0000);
    writeReg(1'b1, 32'h0000_0100);
    cpuProbe("R5 code10", 32'hF100_0000);
    writeReg(1'b1, 32'hFFFF_FFFF);
    cpuProbe("R5 code11", 32'hF100_0000);
    writeReg(1'b1, 32'hFFFF_FEFF);
    cpuProbe("R5 code01 other bits", 32'hF100_0000);
  endtask

  task automatic testAddrPass;
    cpuProbe("R6 pattern", 32'hF3C5_A5A3);
    cpuProbe("R6 pattern2", 32'hFA5A_5A5C);
  endtask

  task automatic testBelowRegion;
    cpuProbe("R12 below", 32'hEFFF_FFFF);
    cpuProbe("R12 zero", 32'h0000_0000);
    cpuProbe("R12 alias", 32'h7100_0000);
  endtask

  task automatic testLatency;
    @(negedge clk);
    cpuValid = 1'b0; cpuAddr = 32'hF100_0000;
    @(posedge clk);
    @(negedge clk);
    check("R2 idle", {31'd0, cpuHit}, 32'd0);
    cpuValid = 1'b1; cpuAddr = 32'hF100_0000;
    @(posedge clk);
    @(negedge clk);
    check("R2 first", {31'd0, cpuHit}, 32'd1);
    cpuAddr = 32'hF000_0000;
    @(posedge clk);
    @(negedge clk);
    check("R2 second", {31'd0, cpuHit}, 32'd0);
    cpuValid = 1'b0;
  endtask

  task automatic testWriteImmediate;
    writeReg(1'b0, 32'h0000_0004);
    cpuProbe("R11 mask new", 32'hF100_0000);
    cpuProbe("R11 mask old chunk", 32'hF180_0000);
    writeReg(1'b1, 32'h0000_0000);
    cpuProbe("R11 ctl off", 32'hF100_0000);
    writeReg(1'b1, 32'h0000_0080);
    cpuProbe("R11 ctl on", 32'hF100_0000);
  endtask

  task automatic testBusMaster;
    bmProbe("R7 zero", 1'b1, 32'h0000_0000);
    bmProbe("R7 edge", 1'b1, 32'hF07F_FFFF);
    bmProbe("R8 low", 1'b1, 32'hF080_0000);
    bmProbe("R8 high", 1'b1, 32'hFF7F_FFFF);
    bmProbe("R10 gap low", 1'b1, 32'hFF80_0000);
    bmProbe("R10 gap high", 1'b1, 32'hFFEF_FFFF);
    bmProbe("R9 low", 1'b1, 32'hFFF0_0000);
    bmProbe("R9 high", 1'b1, 32'hFFFF_FFFF);
    bmProbe("R10 invalid", 1'b0, 32'h1234_5678);
  endtask

  logic done = 1'b0;

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regSel = 1'b0; regWrData = '0;
    cpuValid = 1'b0; cpuAddr = '0; bmValid = 1'b0; bmAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset;
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    testReset;
    testChunkSweep;
    testEdgeChunks;
    testCtlField;
    testAddrPass;
    testBelowRegion;
    testLatency;
    testWriteImmediate;
    testBusMaster;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule